// File: doc/BRIEF.md
# Self-timed single-wire bus master

This block carries out the timed operations of a single-wire open-drain bus once a host has loaded one command. The operations are a reset cycle with presence detection, a byte write, a byte read, a single-bit read/write slot, and a search triplet. A triplet reads two bits, picks a branch direction and writes that direction back, which is the step a device-search walk uses. All slot and reset timing is counted in ticks of an external timebase (nominally 1 µs). Each command picks standard or overdrive timing. After a command is accepted, the block needs no further help from the host until it clears its busy flag.

Commands arrive on a valid/ready pair. `cmd_ready` is high only while the block is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While busy, `cmd_ready` is low, so an offered command is held off and has no effect. The host may keep `cmd_valid` asserted until the block is idle again. `bus_in` must already be synchronised to `clk` by the pad logic.

The results are a status word (busy, presence, short, the two triplet bits and the direction taken) and a read-data byte. Three enables go to the pad: the open-drain pull-down, a short active-pullup assist after each release, and a strong pullup for powering devices after an operation.

Top module: `swb_master`

## Requirements
- R1: After reset, `status` is 0, `rd_data` is 0, `cmd_ready` is 1, and `drive_low`, `apu_en` and `spu_en` are 0.
- R2: Opcodes are 0 reset, 1 write byte, 2 read byte, 3 single bit and 4 triplet. A valid opcode taken with `cmd_valid && cmd_ready` sets `status[0]` (busy) from the next cycle until the operation ends. While busy, `cmd_ready` is 0 and offered commands have no effect. Opcodes 5 to 7 are dropped and do not set busy.
- R3: A reset cycle holds `drive_low` for RST_LOW ticks (480 standard, 48 overdrive). The bus is sampled SHORT ticks after release (8 / 2); if it reads low, `status[2]` (short) is set and `status[1]` (presence) is cleared. Otherwise `status[1]` takes "bus low" sampled PRES ticks after release (70 / 8).
- R4: Write byte sends `cmd_data` least-significant bit first, one slot per bit. A 0 holds the bus low for LOW0 ticks (60 / 8) and a 1 for LOW1 ticks (6 / 1).
- R5: Read byte issues eight 1-slots and samples the bus SAMP ticks (15 / 2) after each slot starts. The bits fill `rd_data` least-significant bit first. `rd_data` changes only when the operation ends.
- R6: Single bit writes `cmd_data[0]` in one slot and reports the sampled bit in `status[3]`.
- R7: Triplet reads bit a, then bit b, then writes the direction d: (a,b)=(0,1) gives d=0, (1,0) gives d=1, (0,0) gives d=`cmd_dir`, and (1,1) gives d=1. The results are a in `status[3]`, b in `status[4]` and d in `status[5]`. a=b=1 is the error indication.
- R8: `cfg_od` at command acceptance selects overdrive (1) or standard (0) timing for the whole operation.
- R9: If `cfg_apu` was 1 at acceptance, `apu_en` is high for APU_TICKS ticks right after each release of the bus, and it is never high together with `drive_low`. If `cfg_apu` was 0, it stays low.
- R10: If `cfg_spu` was 1 at acceptance, `spu_en` rises when the operation ends and stays high until the next accepted command, which clears it. That command raises it again only if its own `cfg_spu` is 1.
- R11: Timing advances only on cycles with `tick` high, so fewer ticks stretch every phase in proportion.
- R12: `drive_low` is never high while busy is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one cycle per tick |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 3 | Opcode (R2) |
| cmd_data | input | DW | Byte to write; bit 0 for single-bit slot |
| cmd_dir | input | 1 | Host direction for triplet ties |
| cfg_od | input | 1 | Overdrive timing select |
| cfg_apu | input | 1 | Active pullup enable |
| cfg_spu | input | 1 | Strong pullup request for this command |
| bus_in | input | 1 | Synchronised bus level |
| drive_low | output | 1 | Pull bus low |
| apu_en | output | 1 | Active pullup assist |
| spu_en | output | 1 | Strong pullup |
| status | output | 6 | {dir, bit b, bit a, short, presence, busy} |
| rd_data | output | DW | Byte received by read byte |

## Verification
Several rules are checked on every cycle, whatever the command: no pull-down while idle, no pullup while the bus is pulled down, strong pullup only while idle, strong pullup cleared by an accepted command, busy following acceptance, and read data held steady during an operation. Timing widths, least-significant-bit-first order, presence and short sampling, the triplet direction table, proportional stretching by the tick rate, and commands held off while busy can only be shown by the bench's scenarios. In those scenarios a behavioural bus device answers the slots, and the bench measures pulse widths.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [2:0] {
    OP_RST = 3'd0,
    OP_WRB = 3'd1,
    OP_RDB = 3'd2,
    OP_BIT = 3'd3,
    OP_TRI = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_GO   = 2'd1,
    S_WAIT = 2'd2
  } seq_st_e;

  localparam int ST_W = 6;
endpackage

// File: rtl/swb_slot_timer.sv
module swb_slot_timer #(
  parameter int STD_SLOT      = 65,
  parameter int STD_LOW1      = 6,
  parameter int STD_LOW0      = 60,
  parameter int STD_SAMP      = 15,
  parameter int STD_RST_LOW   = 480,
  parameter int STD_RST_SHORT = 8,
  parameter int STD_RST_PRES  = 70,
  parameter int STD_RST_REC   = 410,
  parameter int OD_SLOT       = 10,
  parameter int OD_LOW1       = 1,
  parameter int OD_LOW0       = 8,
  parameter int OD_SAMP       = 2,
  parameter int OD_RST_LOW    = 48,
  parameter int OD_RST_SHORT  = 2,
  parameter int OD_RST_PRES   = 8,
  parameter int OD_RST_REC    = 40,
  parameter int APU_TICKS     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic start_rst,
  input  logic start_bit,
  input  logic start_od,
  input  logic bus_in,
  output logic drive_low,
  output logic apu_win,
  output logic slot_done,
  output logic samp_bit,
  output logic pres_seen,
  output logic short_seen
);
  localparam int CW = $clog2(STD_RST_LOW + STD_RST_REC + APU_TICKS + 2);

  logic          active_q, rst_q, wbit_q, od_q;
  logic [CW-1:0] t_q;
  logic [CW-1:0] low1, low0, samp, slot, rlow, rshort, rpres, rend;
  logic [CW-1:0] low_len, end_m1;

  // timing set of the running phase
  always_comb begin
    if (od_q) begin
      low1   = CW'(OD_LOW1);
      low0   = CW'(OD_LOW0);
      samp   = CW'(OD_SAMP);
      slot   = CW'(OD_SLOT);
      rlow   = CW'(OD_RST_LOW);
      rshort = CW'(OD_RST_LOW + OD_RST_SHORT);
      rpres  = CW'(OD_RST_LOW + OD_RST_PRES);
      rend   = CW'(OD_RST_LOW + OD_RST_REC);
    end else begin
      low1   = CW'(STD_LOW1);
      low0   = CW'(STD_LOW0);
      samp   = CW'(STD_SAMP);
      slot   = CW'(STD_SLOT);
      rlow   = CW'(STD_RST_LOW);
      rshort = CW'(STD_RST_LOW + STD_RST_SHORT);
      rpres  = CW'(STD_RST_LOW + STD_RST_PRES);
      rend   = CW'(STD_RST_LOW + STD_RST_REC);
    end
  end

  assign low_len   = rst_q ? rlow : (wbit_q ? low1 : low0);
  assign end_m1    = (rst_q ? rend : slot) - CW'(1);
  assign slot_done = active_q && tick && (t_q == end_m1);
  assign drive_low = active_q && (t_q < low_len);
  assign apu_win   = active_q && (t_q >= low_len) &&
                     ({1'b0, t_q} < ({1'b0, low_len} + (CW+1)'(APU_TICKS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      rst_q      <= 1'b0;
      wbit_q     <= 1'b1;
      od_q       <= 1'b0;
      t_q        <= '0;
      samp_bit   <= 1'b0;
      pres_seen  <= 1'b0;
      short_seen <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      t_q      <= '0;
      rst_q    <= start_rst;
      wbit_q   <= start_bit;
      od_q     <= start_od;
    end else if (active_q && tick) begin
      t_q <= t_q + CW'(1);
      if (t_q == end_m1) active_q <= 1'b0;
      if (!rst_q && t_q == samp)   samp_bit   <= bus_in;
      if (rst_q  && t_q == rshort) short_seen <= !bus_in;
      if (rst_q  && t_q == rpres)  pres_seen  <= !bus_in;
    end
  end
endmodule

// File: rtl/swb_seq.sv
module swb_seq
  import swb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_dir,
  input  logic          cfg_od,
  output logic          cmd_ready,
  output logic          busy,
  output logic          accept,
  output logic          op_done,
  output logic          eng_start,
  output logic          eng_rst,
  output logic          eng_bit,
  output logic          eng_od,
  input  logic          eng_done,
  input  logic          eng_samp,
  input  logic          eng_pres,
  input  logic          eng_short,
  output logic [DW-1:0] rd_data,
  output logic          st_pres,
  output logic          st_short,
  output logic          st_sbit,
  output logic          st_tbit,
  output logic          st_dir
);
  localparam int IW = $clog2(DW);

  seq_st_e       st;
  op_e           op_q;
  logic [DW-1:0] sh;
  logic [IW-1:0] idx;
  logic          dir_q, od_q, b1, b2, wdir, last;

  assign cmd_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign accept    = cmd_ready && cmd_valid && (cmd_op <= 3'd4);
  assign eng_start = (st == S_GO);
  assign eng_rst   = (op_q == OP_RST);
  assign eng_od    = od_q;
  assign op_done   = (st == S_WAIT) && eng_done && last;

  always_comb begin
    case (op_q)
      OP_WRB, OP_RDB: last = (idx == IW'(DW - 1));
      OP_TRI:         last = (idx == IW'(2));
      default:        last = 1'b1;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_WRB, OP_BIT: eng_bit = sh[0];
      OP_TRI:         eng_bit = (idx == IW'(2)) ? wdir : 1'b1;
      default:        eng_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= OP_RST;
      sh       <= '0;
      idx      <= '0;
      dir_q    <= 1'b0;
      od_q     <= 1'b0;
      b1       <= 1'b0;
      b2       <= 1'b0;
      wdir     <= 1'b0;
      rd_data  <= '0;
      st_pres  <= 1'b0;
      st_short <= 1'b0;
      st_sbit  <= 1'b0;
      st_tbit  <= 1'b0;
      st_dir   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q  <= op_e'(cmd_op);
          sh    <= cmd_data;
          idx   <= '0;
          dir_q <= cmd_dir;
          od_q  <= cfg_od;
          st    <= S_GO;
        end
        S_GO: st <= S_WAIT;
        S_WAIT: if (eng_done) begin
          st  <= last ? S_IDLE : S_GO;
          idx <= idx + IW'(1);
          case (op_q)
            OP_RST: begin
              st_pres  <= eng_pres && !eng_short;
              st_short <= eng_short;
            end
            OP_WRB: sh <= sh >> 1;
            OP_RDB: begin
              sh <= {eng_samp, sh[DW-1:1]};
              if (last) rd_data <= {eng_samp, sh[DW-1:1]};
            end
            OP_BIT: st_sbit <= eng_samp;
            OP_TRI: begin
              if (idx == IW'(0)) b1 <= eng_samp;
              else if (idx == IW'(1)) begin
                b2   <= eng_samp;
                wdir <= b1 | (!eng_samp & dir_q);
              end else begin
                st_sbit <= b1;
                st_tbit <= b2;
                st_dir  <= wdir;
              end
            end
            default: ;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swb_master.sv
module swb_master
  import swb_pkg::*;
#(
  parameter int DW            = 8,
  parameter int STD_SLOT      = 65,
  parameter int STD_LOW1      = 6,
  parameter int STD_LOW0      = 60,
  parameter int STD_SAMP      = 15,
  parameter int STD_RST_LOW   = 480,
  parameter int STD_RST_SHORT = 8,
  parameter int STD_RST_PRES  = 70,
  parameter int STD_RST_REC   = 410,
  parameter int OD_SLOT       = 10,
  parameter int OD_LOW1       = 1,
  parameter int OD_LOW0       = 8,
  parameter int OD_SAMP       = 2,
  parameter int OD_RST_LOW    = 48,
  parameter int OD_RST_SHORT  = 2,
  parameter int OD_RST_PRES   = 8,
  parameter int OD_RST_REC    = 40,
  parameter int APU_TICKS     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [DW-1:0]   cmd_data,
  input  logic            cmd_dir,
  input  logic            cfg_od,
  input  logic            cfg_apu,
  input  logic            cfg_spu,
  input  logic            bus_in,
  output logic            drive_low,
  output logic            apu_en,
  output logic            spu_en,
  output logic [ST_W-1:0] status,
  output logic [DW-1:0]   rd_data
);
  logic busy, accept, op_done;
  logic eng_start, eng_rst, eng_bit, eng_od;
  logic eng_done, eng_samp, eng_pres, eng_short, apu_win;
  logic st_pres, st_short, st_sbit, st_tbit, st_dir;
  logic apu_q, spu_arm_q, spu_on_q;

  swb_seq #(.DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_dir(cmd_dir), .cfg_od(cfg_od),
    .cmd_ready(cmd_ready), .busy(busy), .accept(accept), .op_done(op_done),
    .eng_start(eng_start), .eng_rst(eng_rst), .eng_bit(eng_bit), .eng_od(eng_od),
    .eng_done(eng_done), .eng_samp(eng_samp), .eng_pres(eng_pres),
    .eng_short(eng_short), .rd_data(rd_data), .st_pres(st_pres),
    .st_short(st_short), .st_sbit(st_sbit), .st_tbit(st_tbit), .st_dir(st_dir)
  );

  swb_slot_timer #(
    .STD_SLOT(STD_SLOT), .STD_LOW1(STD_LOW1), .STD_LOW0(STD_LOW0),
    .STD_SAMP(STD_SAMP), .STD_RST_LOW(STD_RST_LOW), .STD_RST_SHORT(STD_RST_SHORT),
    .STD_RST_PRES(STD_RST_PRES), .STD_RST_REC(STD_RST_REC),
    .OD_SLOT(OD_SLOT), .OD_LOW1(OD_LOW1), .OD_LOW0(OD_LOW0), .OD_SAMP(OD_SAMP),
    .OD_RST_LOW(OD_RST_LOW), .OD_RST_SHORT(OD_RST_SHORT),
    .OD_RST_PRES(OD_RST_PRES), .OD_RST_REC(OD_RST_REC), .APU_TICKS(APU_TICKS)
  ) tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(eng_start),
    .start_rst(eng_rst), .start_bit(eng_bit), .start_od(eng_od),
    .bus_in(bus_in), .drive_low(drive_low), .apu_win(apu_win),
    .slot_done(eng_done), .samp_bit(eng_samp), .pres_seen(eng_pres),
    .short_seen(eng_short)
  );

  // pullup control: assist per command, strong pullup armed per command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apu_q     <= 1'b0;
      spu_arm_q <= 1'b0;
      spu_on_q  <= 1'b0;
    end else if (accept) begin
      apu_q     <= cfg_apu;
      spu_arm_q <= cfg_spu;
      spu_on_q  <= 1'b0;
    end else if (op_done) begin
      spu_on_q  <= spu_arm_q;
      spu_arm_q <= 1'b0;
    end
  end

  assign apu_en = apu_q && apu_win;
  assign spu_en = spu_on_q;
  assign status = {st_dir, st_tbit, st_sbit, st_short, st_pres, busy};
endmodule

// File: rtl/swb_master_chk.sv
module swb_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          cmd_ready,
  input logic          drive_low,
  input logic          apu_en,
  input logic          spu_en,
  input logic [5:0]    status,
  input logic [DW-1:0] rd_data
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> !drive_low); // R12

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op <= 3'd4) |=> status[0]); // R2

  AST_APU_NOT_WITH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    apu_en |-> !drive_low); // R9

  AST_SPU_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spu_en |-> (!status[0] && !drive_low)); // R10

  AST_SPU_CLEARED_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op <= 3'd4) |=> !spu_en); // R10

  AST_RDATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0])) |-> $stable(rd_data)); // R5
endmodule

bind swb_master swb_master_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .drive_low(drive_low), .apu_en(apu_en),
  .spu_en(spu_en), .status(status), .rd_data(rd_data)
);

// File: tb/swb_master_tb_top.sv
module swb_master_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, tick = 1'b1, cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0, rd_data;
  logic       cmd_dir = 1'b0, cfg_od = 1'b0, cfg_apu = 1'b0, cfg_spu = 1'b0;
  logic       bus_in, drive_low, apu_en, spu_en;
  logic [5:0] status;

  bit slave_low = 0, short_mode = 0, reset_mode = 0, pres_en = 0, sparse = 0;
  bit cur_bit = 1, prev_drv = 0, spu_exp = 0;
  bit resp[$];
  int widths[$];
  int c = 1000, run = 0, apu_cnt = 0, spu_mis = 0, idle_mis = 0;
  int sl_low = 48, sl_sh = 2, sl_pr = 8, sl_samp = 2, lo1 = 1, lo0 = 8;
  int tests = 0, fails = 0;

  assign bus_in = !(drive_low || slave_low || short_mode);

  swb_master dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_dir(cmd_dir), .cfg_od(cfg_od), .cfg_apu(cfg_apu), .cfg_spu(cfg_spu),
    .bus_in(bus_in), .drive_low(drive_low), .apu_en(apu_en), .spu_en(spu_en),
    .status(status), .rd_data(rd_data)
  );

  // behavioural bus device
  always @(negedge clk) begin
    if (drive_low && !prev_drv) begin
      c = 0;
      if (!reset_mode) cur_bit = (resp.size() > 0) ? resp.pop_front() : 1'b1;
    end else c++;
    prev_drv = drive_low;
    if (reset_mode) slave_low = pres_en && c >= sl_low + sl_sh + 2 && c <= sl_low + sl_pr + 4;
    else            slave_low = !cur_bit && c >= 1 && c <= sl_samp + 1;
    tick = sparse ? ~tick : 1'b1;
  end

  // per-clock monitor and reference comparison
  always @(negedge clk) begin
    #1;
    if (drive_low) run++;
    else if (run > 0) begin widths.push_back(run); run = 0; end
    if (apu_en) apu_cnt++;
    if (rst_n) begin
      if (spu_en !== spu_exp) spu_mis++;
      if (drive_low && !status[0]) idle_mis++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int decode();
    int v = 0;
    for (int i = 0; i < widths.size() && i < 8; i++) if (widths[i] == lo1) v |= (1 << i);
    return v;
  endfunction

  function automatic int bad_widths();
    int n = 0;
    foreach (widths[i]) if (widths[i] != lo1 && widths[i] != lo0) n++;
    return n;
  endfunction

  task automatic run_op(input int op, input int data, input bit dir, input bit od,
                        input bit apu, input bit spu, input bit poke);
    bit armed;
    sl_low = od ? 48 : 480; sl_sh = od ? 2 : 8; sl_pr = od ? 8 : 70;
    sl_samp = od ? 2 : 15; lo1 = od ? 1 : 6; lo0 = od ? 8 : 60;
    reset_mode = (op == 0);
    @(negedge clk);
    widths.delete(); apu_cnt = 0;
    cmd_valid = 1; cmd_op = 3'(op); cmd_data = 8'(data); cmd_dir = dir;
    cfg_od = od; cfg_apu = apu; cfg_spu = spu;
    @(negedge clk);
    spu_exp = 0; armed = spu;
    cmd_valid = 0; cfg_apu = 0; cfg_spu = 0; cfg_od = ~od;
    if (poke) begin
      cmd_valid = 1; cmd_op = 3'd1; cmd_data = 8'h00;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        chk("R2 cmd_ready low while busy", cmd_ready, 0);
      end
      cmd_valid = 0;
    end
    while (status[0]) @(negedge clk);
    spu_exp = armed;
    @(negedge clk);
  endtask

  task automatic triplet(input bit a, input bit b, input bit hdir);
    int d = (a != b) ? a : (a ? 1 : hdir);
    resp.delete(); resp.push_back(a); resp.push_back(b); resp.push_back(1'b1);
    run_op(4, 0, hdir, 1, 0, 0, 0);
    chk("R7 triplet bit a", status[3], a);
    chk("R7 triplet bit b", status[4], b);
    chk("R7 triplet direction", status[5], d);
    chk("R7 written direction width", widths.size() == 3 ? widths[2] : -1, d ? lo1 : lo0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status after reset", status, 0);
    chk("R1 rd_data after reset", rd_data, 0);
    chk("R1 cmd_ready after reset", cmd_ready, 1);
    chk("R1 enables after reset", {drive_low, apu_en, spu_en}, 0);

    pres_en = 1; run_op(0, 0, 0, 1, 0, 0, 0);
    chk("R3 overdrive reset low width", widths.size() ? widths[0] : -1, 48);
    chk("R3 presence seen", status[1], 1);
    chk("R3 no short", status[2], 0);
    pres_en = 0; run_op(0, 0, 0, 1, 0, 0, 0);
    chk("R3 no presence", status[1], 0);
    short_mode = 1; run_op(0, 0, 0, 1, 0, 0, 0); short_mode = 0;
    chk("R3 short flagged", status[2], 1);
    chk("R3 presence cleared on short", status[1], 0);
    pres_en = 1; run_op(0, 0, 0, 0, 0, 0, 0);
    chk("R8 standard reset low width", widths.size() ? widths[0] : -1, 480);
    chk("R8 standard presence", status[1], 1);
    chk("R3 short clear after good reset", status[2], 0);
    pres_en = 0;

    run_op(1, 8'hA5, 0, 1, 0, 0, 0);
    chk("R4 write slot count", widths.size(), 8);
    chk("R4 write byte lsb first", decode(), 8'hA5);
    chk("R4 write widths legal", bad_widths(), 0);
    run_op(1, 8'h3C, 0, 0, 0, 0, 0);
    chk("R8 standard write byte", decode(), 8'h3C);
    chk("R8 standard write widths", bad_widths(), 0);

    resp.delete();
    for (int i = 0; i < 8; i++) resp.push_back(((8'h6B >> i) & 1) != 0);
    run_op(2, 0, 0, 1, 0, 0, 0);
    chk("R5 read byte value", rd_data, 8'h6B);
    chk("R5 read slots are 1-slots", decode(), 8'hFF);

    resp.delete(); resp.push_back(1'b0); run_op(3, 1, 0, 1, 0, 0, 0);
    chk("R6 bit read 0", status[3], 0);
    resp.delete(); resp.push_back(1'b1); run_op(3, 1, 0, 1, 0, 0, 0);
    chk("R6 bit read 1", status[3], 1);
    resp.delete(); resp.push_back(1'b1); run_op(3, 0, 0, 1, 0, 0, 0);
    chk("R6 bit write 0 width", widths.size() ? widths[0] : -1, 8);
    chk("R6 bit write 0 reads 0", status[3], 0);

    triplet(0, 1, 1);
    triplet(1, 0, 0);
    triplet(0, 0, 1);
    triplet(0, 0, 0);
    triplet(1, 1, 0);

    run_op(0, 0, 0, 1, 1, 0, 0);
    chk("R9 assist ticks after reset release", apu_cnt, 2);
    run_op(1, 8'h5A, 0, 1, 1, 0, 0);
    chk("R9 assist ticks over byte", apu_cnt, 16);
    run_op(1, 8'h5A, 0, 1, 0, 0, 0);
    chk("R9 no assist when disabled", apu_cnt, 0);

    run_op(3, 1, 0, 1, 0, 1, 0);
    chk("R10 strong pullup after op", spu_en, 1);
    repeat (20) @(negedge clk);
    chk("R10 strong pullup held while idle", spu_en, 1);
    run_op(3, 1, 0, 1, 0, 0, 0);
    chk("R10 strong pullup not rearmed", spu_en, 0);

    @(negedge clk); cmd_valid = 1; cmd_op = 3'd6;
    @(negedge clk); cmd_valid = 0;
    chk("R2 reserved opcode ignored", status[0], 0);

    resp.delete();
    for (int i = 0; i < 8; i++) resp.push_back(((8'hC3 >> i) & 1) != 0);
    run_op(2, 0, 0, 1, 0, 0, 1);
    chk("R2 held-off command no effect on read", rd_data, 8'hC3);
    chk("R2 held-off command no extra slots", widths.size(), 8);

    sparse = 1; run_op(0, 0, 0, 1, 0, 0, 0); sparse = 0;
    chk("R11 half tick rate doubles low", (widths.size() && widths[0] >= 95 && widths[0] <= 97) ? 1 : 0, 1);

    chk("R10 per-clock strong pullup model", spu_mis, 0);
    chk("R12 per-clock idle drive", idle_mis, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule